// File: doc/BRIEF.md
# Three-Level PWM Gate Sequencer

This block sits between a buck controller's three-level PWM output and the gate drivers of a synchronous buck stage. Each cycle it takes an already-sliced PWM level (low, mid or high), a zero-current mode setting that is sliced the same way, an enable, and one bit from a zero-current comparator. From these it drives two gate enables: `gh` for the high-side switch and `gl` for the low-side switch. All timing is counted in clock cycles and set by parameters.

The PWM level has to stay steady for `FILT_CYC` samples before the sequencer acts on it, so short spikes never reach the gates. Every hand-off between the two gates passes through `DEAD_CYC` cycles in which both gates are low. A high-side pulse is stretched to at least `MIN_ON_CYC` cycles. In the two diode-emulation modes, a mid command keeps `gh` on for a hold-off window before it is dropped. The low-side gate then runs a blanking window of `BLANK_CYC` cycles, and after that window it is cut by the comparator. In the zero-current mode low, a mid command turns off both gates at once.

Top module: `tri_pwm_gate_seq`

## Requirements
- R1: During reset both gates are low. When `en` is low at a clock edge, both gates are low from the next cycle on, whatever the PWM level.
- R2: The PWM level is coded 2'b00 low, 2'b01 mid, 2'b10 high, with 2'b11 read as mid. A level is accepted only after it has been sampled on `FILT_CYC` consecutive edges, and any shorter excursion is ignored. An accepted level acts on the state register `FILT_CYC`+2 cycles after it is applied.
- R3: An accepted high level turns `gl` off and then turns `gh` on. With `zc_mode` at 2'b00, an accepted low level turns `gh` off and then keeps `gl` on for as long as the level stays low.
- R4: `gh` and `gl` are never high together. Each gate rises only after at least `DEAD_CYC` cycles in which both gates have been low since the other gate fell.
- R5: Once `gh` rises it stays high for at least `MIN_ON_CYC` cycles. Only `en` low or a mid level in mode 2'b00 can cut it short.
- R6: With `zc_mode` at 2'b00, a mid level takes both gates low right away, with no hold-off, no minimum on-time and no dead-time wait, and `gl` stays low afterwards.
- R7: With `zc_mode` at 2'b01 or 2'b10, a mid level keeps `gh` high for `HOLD_CYC` cycles, counted from the first cycle in which the state machine sees mid. If high returns within that window, `gh` never drops.
- R8: With `zc_mode` at 2'b10, after the hold-off a mid level gives `gl` on, following the dead time. `gl` then stays on for `BLANK_CYC` cycles whatever `zc_det` does, and after that it turns off one cycle after `zc_det` is sampled high. If `zc_det` is held high throughout, `gl` is high for exactly `BLANK_CYC`+1 cycles.
- R9: With `zc_mode` at 2'b01, a low level gives `gl` on through the blanking window and then off on `zc_det`. A mid level turns `gh` off after the hold-off and leaves `gl` low.
- R10: With `zc_mode` at 2'b10, a move from mid to low turns `gl` on, and its blanking window runs from the cycle `gl` rises. If the level goes back to mid before the window ends, `gl` still completes the window and then waits for `zc_det`.
- R11: After `zc_det` has ended a low-side pulse, `gl` stays low until the accepted PWM level changes, even if `zc_det` drops again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low forces both gates off |
| pwm_lvl | input | 2 | Sliced PWM level: 00 low, 01 mid, 10 high, 11 read as mid |
| zc_mode | input | 2 | Zero-current mode: 00 forced-continuous, 01 diode emulation on low, 10 diode emulation on mid |
| zc_det | input | 1 | Zero-current comparator output, high when the inductor current has reached zero |
| gh | output | 1 | High-side gate enable |
| gl | output | 1 | Low-side gate enable |

## Verification
The bench sends a one-sample PWM spike, which a design without a working filter would turn into a gate pulse, and a pulse just long enough to be accepted, which must come out stretched to the minimum on-time rather than clipped. It returns the level from mid to high inside the hold-off window to catch a design that drops `gh` too early. It holds `zc_det` high through the whole blanking window to catch a design that cuts `gl` before the window ends. It runs the mid-low-mid case in mode 2'b10; a design that restarts or abandons the window when mid returns would give the wrong `gl` width. It also checks that a mid level in mode 2'b00 cuts `gh` short, that `gl` stays low after a zero-current cut even when `zc_det` falls again, and that the count of dead cycles between every hand-off never drops below the limit.

// File: rtl/tri_pwm_gate_seq.sv
module tri_pwm_gate_seq #(
  parameter int FILT_CYC   = 1,
  parameter int DEAD_CYC   = 2,
  parameter int MIN_ON_CYC = 5,
  parameter int HOLD_CYC   = 5,
  parameter int BLANK_CYC  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pwm_lvl,
  input  logic [1:0] zc_mode,
  input  logic       zc_det,
  output logic       gh,
  output logic       gl
);

  localparam logic [1:0] LV_LO  = 2'b00;
  localparam logic [1:0] LV_MID = 2'b01;
  localparam logic [1:0] LV_HI  = 2'b10;
  localparam int TMAX = (DEAD_CYC > BLANK_CYC) ? DEAD_CYC : BLANK_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int FW   = $clog2(FILT_CYC + 1);
  localparam int AW   = $clog2(MIN_ON_CYC + 1);
  localparam int HW   = $clog2(HOLD_CYC + 1);
  localparam logic [TW-1:0] DEAD_LAST  = TW'(DEAD_CYC - 1);
  localparam logic [TW-1:0] BLANK_LAST = TW'(BLANK_CYC - 1);

  typedef enum logic [2:0] {
    S_OFF, S_DHS, S_HS, S_DLS, S_LSC, S_BLK, S_ZW, S_DONE
  } state_t;

  logic [1:0]    lvl_in, mode;
  logic [1:0]    cand, cmd;
  logic [FW-1:0] run;
  logic          cmd_new;
  state_t        st;
  logic [TW-1:0] tcnt;
  logic [AW-1:0] age;
  logic [HW-1:0] ho, ho_nx;
  logic          ls_blk;

  assign lvl_in = (pwm_lvl == 2'b11) ? LV_MID : pwm_lvl;
  assign mode   = (zc_mode == 2'b11) ? LV_MID : zc_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand    <= LV_LO;
      run     <= '0;
      cmd     <= LV_LO;
      cmd_new <= 1'b0;
    end else begin
      cmd_new <= 1'b0;
      if (run >= FW'(FILT_CYC)) begin
        cmd     <= cand;
        cmd_new <= (cand != cmd);
      end
      if (lvl_in != cand) begin
        cand <= lvl_in;
        run  <= FW'(1);
      end else if (run < FW'(FILT_CYC)) begin
        run <= run + 1'b1;
      end
    end
  end

  logic cmd_hi, cmd_lo, cmd_mid, zm_lo, zm_mid, zm_hi, age_ok, ho_done;
  assign cmd_hi  = (cmd == LV_HI);
  assign cmd_lo  = (cmd == LV_LO);
  assign cmd_mid = (cmd == LV_MID);
  assign zm_lo   = (mode == LV_LO);
  assign zm_mid  = (mode == LV_MID);
  assign zm_hi   = (mode == LV_HI);
  assign age_ok  = (age >= AW'(MIN_ON_CYC));
  assign ho_nx   = (ho < HW'(HOLD_CYC)) ? ho + 1'b1 : ho;
  assign ho_done = cmd_mid && (ho_nx >= HW'(HOLD_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      tcnt   <= '0;
      age    <= '0;
      ho     <= '0;
      ls_blk <= 1'b0;
    end else if (!en) begin
      st   <= S_OFF;
      tcnt <= '0;
      age  <= '0;
      ho   <= '0;
    end else begin
      case (st)
        S_OFF: begin
          tcnt <= '0;
          if (cmd_hi) st <= S_DHS;
          else if (cmd_lo) begin
            st     <= S_DLS;
            ls_blk <= !zm_lo;
          end else if (zm_hi) begin
            st     <= S_DLS;
            ls_blk <= 1'b1;
          end
        end
        S_DHS: begin
          if (tcnt == DEAD_LAST) begin
            st  <= S_HS;
            age <= AW'(1);
            ho  <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        S_HS: begin
          tcnt <= '0;
          if (!age_ok) age <= age + 1'b1;
          ho <= cmd_mid ? ho_nx : '0;
          if (cmd_mid && zm_lo) st <= S_OFF;
          else if (cmd_lo && age_ok) begin
            st     <= S_DLS;
            ls_blk <= zm_mid;
          end else if (ho_done && age_ok) begin
            if (zm_hi) begin
              st     <= S_DLS;
              ls_blk <= 1'b1;
            end else st <= S_OFF;
          end
        end
        S_DLS: begin
          if (tcnt == DEAD_LAST) begin
            st   <= ls_blk ? S_BLK : S_LSC;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        S_LSC: begin
          tcnt <= '0;
          if (cmd_hi) st <= S_DHS;
          else if (cmd_mid) st <= zm_hi ? S_BLK : S_OFF;
        end
        S_BLK: begin
          if (cmd_hi) begin
            st   <= S_DHS;
            tcnt <= '0;
          end else if (cmd_mid && !zm_hi) st <= S_OFF;
          else if (tcnt == BLANK_LAST) begin
            st   <= (cmd_lo && !zm_mid) ? S_LSC : S_ZW;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        S_ZW: begin
          tcnt <= '0;
          if (cmd_hi) st <= S_DHS;
          else if (cmd_mid && !zm_hi) st <= S_OFF;
          else if (cmd_lo && !zm_mid) st <= S_LSC;
          else if (zc_det) st <= S_DONE;
        end
        S_DONE: begin
          tcnt <= '0;
          if (cmd_new) st <= S_OFF;
        end
        default: st <= S_OFF;
      endcase
    end
  end

  assign gh = (st == S_HS);
  assign gl = (st == S_LSC) || (st == S_BLK) || (st == S_ZW);

endmodule

// File: rtl/tri_pwm_gate_seq_chk.sv
module tri_pwm_gate_seq_chk #(
  parameter int DEAD_CYC   = 2,
  parameter int MIN_ON_CYC = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] zc_mode,
  input logic       gh,
  input logic       gl
);

  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int MW = $clog2(MIN_ON_CYC + 1);

  logic [DW-1:0] since_gl, since_gh;
  logic [MW-1:0] on_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_gl <= DW'(DEAD_CYC);
      since_gh <= DW'(DEAD_CYC);
      on_run   <= '0;
    end else begin
      if (gl) since_gl <= '0;
      else if (since_gl < DW'(DEAD_CYC)) since_gl <= since_gl + 1'b1;
      if (gh) since_gh <= '0;
      else if (since_gh < DW'(DEAD_CYC)) since_gh <= since_gh + 1'b1;
      if (!gh) on_run <= '0;
      else if (on_run < MW'(MIN_ON_CYC)) on_run <= on_run + 1'b1;
    end
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh && gl));

  // R4
  gh_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh) |-> (since_gl >= DW'(DEAD_CYC)));

  // R4
  gl_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl) |-> (since_gh >= DW'(DEAD_CYC)));

  // R1
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gh && !gl));

  // R5
  min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gh) && $past(en) && ($past(zc_mode) != 2'b00)) |-> (on_run >= MW'(MIN_ON_CYC)));

endmodule

bind tri_pwm_gate_seq tri_pwm_gate_seq_chk #(
  .DEAD_CYC(DEAD_CYC),
  .MIN_ON_CYC(MIN_ON_CYC)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .en(en),
  .zc_mode(zc_mode),
  .gh(gh),
  .gl(gl)
);

// File: tb/tri_pwm_gate_seq_test.sv
module tri_pwm_gate_seq_test;

  localparam int FILT  = 2;
  localparam int DEAD  = 2;
  localparam int MINON = 5;
  localparam int HOLD  = 5;
  localparam int BLANK = 8;
  localparam int LAT   = FILT + 2;
  localparam logic [1:0] P_LO  = 2'b00;
  localparam logic [1:0] P_MID = 2'b01;
  localparam logic [1:0] P_HI  = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n, en, zc;
  logic [1:0] pwm, zm;
  logic       gh, gl;
  int n_chk = 0;
  int n_fail = 0;
  int overlap = 0;
  int dead_err = 0;

  always #4 clk = ~clk;

  tri_pwm_gate_seq #(
    .FILT_CYC(FILT), .DEAD_CYC(DEAD), .MIN_ON_CYC(MINON),
    .HOLD_CYC(HOLD), .BLANK_CYC(BLANK)
  ) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_lvl(pwm),
    .zc_mode(zm), .zc_det(zc), .gh(gh), .gl(gl)
  );

  int owner = 0;
  int quiet = 0;
  logic p_gh = 1'b0;
  logic p_gl = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (gh && gl) overlap++;
      if (gh && !p_gh && owner == 2 && quiet < DEAD) dead_err++;
      if (gl && !p_gl && owner == 1 && quiet < DEAD) dead_err++;
      if (gh) begin owner = 1; quiet = 0; end
      else if (gl) begin owner = 2; quiet = 0; end
      else quiet++;
      p_gh = gh;
      p_gl = gl;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_gate(input bit sel_gh, input bit val, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((sel_gh ? gh : gl) != val) && n < 100);
  endtask

  task automatic width_of(input bit sel_gh, output int w);
    w = 0;
    while ((sel_gh ? gh : gl) == 1'b1 && w < 200) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic hold_check(input bit sel_gh, input bit val, input int n, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((sel_gh ? gh : gl) != val) bad++;
    end
  endtask

  task automatic t_disabled;
    int b1, b2;
    en = 1'b0;
    pwm = P_HI;
    hold_check(1, 0, 12, b1);
    chk(b1 == 0, "R1 gh while disabled", b1, 0);
    hold_check(0, 0, 1, b2);
    chk(b2 == 0, "R1 gl while disabled", b2, 0);
    pwm = P_LO;
    en = 1'b1;
    step(12);
    chk(gl && !gh, "R3 low level in mode 00", {gh, gl}, 1);
  endtask

  task automatic t_sync;
    int n;
    pwm = P_HI;
    wait_gate(0, 0, n);
    chk(n == LAT, "R3 gl off after high", n, LAT);
    wait_gate(1, 1, n);
    chk(n == DEAD, "R4 dead before gh", n, DEAD);
    step(10);
    pwm = P_LO;
    wait_gate(1, 0, n);
    chk(n == LAT, "R3 gh off after low", n, LAT);
    wait_gate(0, 1, n);
    chk(n == DEAD, "R4 dead before gl", n, DEAD);
  endtask

  task automatic t_glitch;
    int bad;
    pwm = P_HI;
    @(negedge clk);
    pwm = P_LO;
    hold_check(1, 0, 12, bad);
    chk(bad == 0, "R2 short spike ignored", bad, 0);
    chk(gl == 1'b1, "R2 gl kept on", gl, 1);
  endtask

  task automatic t_min_on;
    int n, w;
    pwm = P_HI;
    step(FILT);
    pwm = P_LO;
    wait_gate(1, 1, n);
    chk(n + FILT == LAT + DEAD, "R2 minimal pulse accepted", n + FILT, LAT + DEAD);
    width_of(1, w);
    chk(w == MINON, "R5 pulse stretched", w, MINON);
    step(10);
  endtask

  task automatic t_mid_low_mode;
    int n, w, bad;
    pwm = P_HI;
    step(12);
    pwm = P_MID;
    wait_gate(1, 0, n);
    chk(n == LAT, "R6 gh off at once", n, LAT);
    hold_check(0, 0, 10, bad);
    chk(bad == 0, "R6 gl stays off", bad, 0);
    pwm = P_LO;
    step(12);
    pwm = P_MID;
    wait_gate(0, 0, n);
    chk(n == LAT, "R6 gl off at once", n, LAT);
    pwm = P_HI;
    wait_gate(1, 1, n);
    pwm = P_MID;
    width_of(1, w);
    chk(w == LAT, "R6 min on-time overridden", w, LAT);
  endtask

  task automatic t_holdoff;
    int b1, b2;
    zm = P_HI;
    pwm = P_HI;
    step(12);
    pwm = P_MID;
    hold_check(1, 1, 3, b1);
    pwm = P_HI;
    hold_check(1, 1, 12, b2);
    chk(b1 + b2 == 0, "R7 gh kept through short mid", b1 + b2, 0);
  endtask

  task automatic t_zcd_high;
    int n, bad;
    zc = 1'b0;
    pwm = P_MID;
    wait_gate(1, 0, n);
    chk(n == LAT + HOLD - 1, "R7 hold-off length", n, LAT + HOLD - 1);
    wait_gate(0, 1, n);
    chk(n == DEAD, "R8 gl after dead", n, DEAD);
    hold_check(0, 1, 20, bad);
    chk(bad == 0, "R8 gl waits for zero current", bad, 0);
    zc = 1'b1;
    wait_gate(0, 0, n);
    chk(n == 1, "R8 gl cut by zc_det", n, 1);
    zc = 1'b0;
    hold_check(0, 0, 10, bad);
    chk(bad == 0, "R11 gl stays off after cut", bad, 0);
  endtask

  task automatic t_blank_ignore;
    int n, w;
    pwm = P_HI;
    step(14);
    zc = 1'b1;
    pwm = P_MID;
    wait_gate(0, 1, n);
    chk(n == LAT + HOLD - 1 + DEAD, "R8 gl rise time", n, LAT + HOLD - 1 + DEAD);
    width_of(0, w);
    chk(w == BLANK + 1, "R8 blanking ignores zc_det", w, BLANK + 1);
    zc = 1'b0;
  endtask

  task automatic t_mid_low_mid;
    int n, w, bad;
    pwm = P_LO;
    wait_gate(0, 1, n);
    chk(n == LAT + 1 + DEAD, "R10 gl on from mid to low", n, LAT + 1 + DEAD);
    pwm = P_MID;
    zc = 1'b1;
    width_of(0, w);
    chk(w == BLANK + 1, "R10 blank completes after return to mid", w, BLANK + 1);
    zc = 1'b0;
    hold_check(0, 0, 8, bad);
    chk(bad == 0, "R11 gl off after zc_det drops", bad, 0);
  endtask

  task automatic t_zcd_mid;
    int n, bad;
    zm = P_MID;
    pwm = P_HI;
    step(14);
    pwm = P_LO;
    wait_gate(1, 0, n);
    chk(n == LAT, "R9 gh off on low", n, LAT);
    wait_gate(0, 1, n);
    chk(n == DEAD, "R9 gl on after dead", n, DEAD);
    hold_check(0, 1, 15, bad);
    chk(bad == 0, "R9 gl held until zero current", bad, 0);
    zc = 1'b1;
    wait_gate(0, 0, n);
    chk(n == 1, "R9 gl cut by zc_det", n, 1);
    step(3);
    zc = 1'b0;
    hold_check(0, 0, 6, bad);
    chk(bad == 0, "R11 gl off while low persists", bad, 0);
    pwm = P_HI;
    step(14);
    pwm = P_MID;
    wait_gate(1, 0, n);
    chk(n == LAT + HOLD - 1, "R9 gh off after hold-off", n, LAT + HOLD - 1);
    hold_check(0, 0, 12, bad);
    chk(bad == 0, "R9 mid leaves gl off", bad, 0);
  endtask

  task automatic t_disable_drop;
    int n;
    pwm = P_HI;
    step(14);
    chk(gh == 1'b1, "R3 gh on before disable", gh, 1);
    en = 1'b0;
    wait_gate(1, 0, n);
    chk(n == 1, "R1 disable drops gh", n, 1);
    en = 1'b1;
    step(4);
  endtask

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    pwm = P_LO;
    zm = P_LO;
    zc = 1'b0;
    step(4);
    chk(!gh && !gl, "R1 reset state", {gh, gl}, 0);
    rst_n = 1'b1;
    t_disabled();
    t_sync();
    t_glitch();
    t_min_on();
    t_mid_low_mode();
    t_holdoff();
    t_zcd_high();
    t_blank_ignore();
    t_mid_low_mid();
    t_zcd_mid();
    t_disable_drop();
    chk(overlap == 0, "R4 gates never overlap", overlap, 0);
    chk(dead_err == 0, "R4 dead time on every hand-off", dead_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule